// File: doc/BRIEF.md
# Write-Protect Command Detector

This block sits on the byte-write path of a single nonvolatile memory device and decides, write by write, whether the store may reach the array. It keeps one protect flag that models a nonvolatile bit. The flag starts cleared, so every write goes through. Two fixed runs of address/data writes change it. A three-write run arms protection. A six-write run removes it. Each flag change is applied only after a programmable write-cycle delay, and `busy_o` is high for that delay.

While the flag is set, ordinary writes are refused. The three-write run is still accepted in that state. It then opens a single page window, and up to one page of data writes may follow. All of them must fall in the page that the first of them selects. The window closes when a full page has been written, when a write goes to a different page, or when the next write does not arrive within the byte-load timeout. After that the device is protected again without any delay. Each device of a multi-device array gets its own instance, so each device keeps its own flag.

The command pairs are parameters. A write that belongs to a command run is consumed by the detector and is never passed to the array. A write that breaks a run sends the matcher back to idle. That write is then judged as an ordinary write under the current flag.

Top module: `wp_cmd_detect`

## Requirements
- R1: After reset `prot_o` and `busy_o` are 0, and an ordinary write gets `permit_o` = 1.
- R2: While unprotected and not busy, a write that does not match the next expected command step gets `permit_o` = 1 in the same cycle as `wr_i`.
- R3: Writing (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0) in that order while unprotected gives `permit_o` = 0 on each of the three writes. `busy_o` rises one cycle after the third write and stays high for exactly TWC_CYCLES cycles. `prot_o` becomes 1 in the same cycle that `busy_o` falls.
- R4: While `busy_o` is 1, every write gets `permit_o` = 0 and does not advance any command run.
- R5: While protected and no page window is open, any write that is not a command step gets `permit_o` = 0.
- R6: While protected, the three-write run of R3 opens a page window without raising `busy_o`. The following writes whose page (addr_i[AW-1:PAGE_BITS]) equals that of the first of them are permitted, up to 2^PAGE_BITS writes. The write after a full page gets `permit_o` = 0.
- R7: A window write to a page other than the latched one gets `permit_o` = 0 and closes the window. Later writes to the latched page are then refused.
- R8: The window closes after LOAD_WIN_CYCLES consecutive cycles with no write. This applies whether or not a data write has occurred. `prot_o` stays 1 and `busy_o` stays 0 when it closes.
- R9: Writing (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x20) gives `permit_o` = 0 on each of the six writes. `busy_o` is then high for TWC_CYCLES cycles, and `prot_o` becomes 0 as it falls.
- R10: A write that breaks a partial run returns the matcher to idle and is judged as an ordinary write. Sending the remaining steps of the broken run afterwards does not complete it.
- R11: The two runs are tracked in parallel. A clear-run prefix (AA, 55, 80) followed by AA, 55, A0 completes the set run on the sixth write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | One-cycle byte-write strobe |
| addr_i | input | AW | Byte address of the write |
| data_i | input | DW | Data byte of the write |
| permit_o | output | 1 | The current write may reach the array (combinational) |
| prot_o | output | 1 | Protect flag |
| busy_o | output | 1 | Flag update in progress; writes are ignored |

## Verification
The bench goes after the shared prefix of the two runs. A matcher that tracked only one run would miss the set completion after a clear prefix and leave the device unprotected. Writes sent during the busy period are chosen so that, if they advanced a matcher, a later lone command write would open a page window and let data through. The page window is driven to its full-page limit, to a foreign page and to its idle timeout. An off-by-one count or a forgotten window close shows up there as a leaked write. The busy length is compared against the reference model on every cycle, so a delay that is one cycle short or long is caught.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    FLAG_OFF = 1'b0,
    FLAG_ON  = 1'b1
  } flag_e;
endpackage

// File: rtl/wp_seq_match.sv
module wp_seq_match #(
  parameter int AW  = 17,
  parameter int DW  = 8,
  parameter int LEN = 3,
  parameter logic [LEN*AW-1:0] ADDRS = '0,
  parameter logic [LEN*DW-1:0] DATAS = '0,
  localparam int IW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          hit_o,
  output logic          done_o
);
  logic [IW-1:0] idx_q;
  logic [LEN-1:0] elem_hit;

  // step i of the run sits at slice i of the packed pairs
  for (genvar g = 0; g < LEN; g++) begin : g_elem
    assign elem_hit[g] = (idx_q == IW'(g)) &&
                         (addr_i == ADDRS[g*AW +: AW]) &&
                         (data_i == DATAS[g*DW +: DW]);
  end

  assign hit_o  = step_i && (|elem_hit);
  assign done_o = hit_o && (idx_q == IW'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (step_i) begin
      if (hit_o && !done_o) idx_q <= idx_q + IW'(1);
      else                  idx_q <= '0;
    end
  end

  assert_idx_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IW'(LEN));

  assert_hold_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(idx_q));
endmodule

// File: rtl/wp_flag_timer.sv
module wp_flag_timer
  import wp_pkg::*;
#(
  parameter int TWC_CYCLES = 625000,
  localparam int CW = $clog2(TWC_CYCLES + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  flag_e target_i,
  output logic  busy_o,
  output logic  prot_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  flag_e         pend_q;
  flag_e         prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= FLAG_OFF;
      prot_q <= FLAG_OFF;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        prot_q <= pend_q;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(TWC_CYCLES - 1);
      pend_q <= target_i;
    end
  end

  assign busy_o = busy_q;
  assign prot_o = (prot_q == FLAG_ON);

  assert_flag_moves_on_busy_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prot_q) |-> $fell(busy_q));

  assert_no_start_when_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);

  assert_busy_after_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
endmodule

// File: rtl/wp_page_window.sv
module wp_page_window #(
  parameter int AW              = 17,
  parameter int PAGE_BITS       = 8,
  parameter int LOAD_WIN_CYCLES = 12500,
  localparam int PW         = AW - PAGE_BITS,
  localparam int PAGE_BYTES = 1 << PAGE_BITS,
  localparam int BW         = PAGE_BITS + 1,
  localparam int TW         = $clog2(LOAD_WIN_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  output logic          active_o,
  output logic          permit_o
);
  logic          active_q;
  logic          page_vld_q;
  logic [PW-1:0] page_q;
  logic [BW-1:0] bytes_q;
  logic [TW-1:0] idle_q;
  logic          same_page;

  assign same_page = !page_vld_q || (addr_i[AW-1:PAGE_BITS] == page_q);
  assign active_o  = active_q;
  assign permit_o  = active_q && wr_i && same_page;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      page_vld_q <= 1'b0;
      page_q     <= '0;
      bytes_q    <= '0;
      idle_q     <= '0;
    end else if (open_i) begin
      active_q   <= 1'b1;
      page_vld_q <= 1'b0;
      bytes_q    <= '0;
      idle_q     <= '0;
    end else if (active_q) begin
      if (wr_i) begin
        idle_q <= '0;
        if (same_page) begin
          page_vld_q <= 1'b1;
          page_q     <= addr_i[AW-1:PAGE_BITS];
          bytes_q    <= bytes_q + BW'(1);
          if (bytes_q == BW'(PAGE_BYTES - 1)) active_q <= 1'b0;
        end else begin
          active_q <= 1'b0;
        end
      end else if (idle_q == TW'(LOAD_WIN_CYCLES - 1)) begin
        active_q <= 1'b0;
      end else begin
        idle_q <= idle_q + TW'(1);
      end
    end
  end

  assert_page_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bytes_q <= BW'(PAGE_BYTES));

  assert_foreign_page_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && wr_i && !same_page && !open_i) |=> !active_q);
endmodule

// File: rtl/wp_cmd_detect.sv
module wp_cmd_detect
  import wp_pkg::*;
#(
  parameter int AW              = 17,
  parameter int DW              = 8,
  parameter int PAGE_BITS       = 8,
  parameter int TWC_CYCLES      = 625000,
  parameter int LOAD_WIN_CYCLES = 12500,
  parameter int SET_LEN         = 3,
  parameter int CLR_LEN         = 6,
  // step 0 in the least significant slice
  parameter logic [SET_LEN*AW-1:0] SET_ADDRS = {17'h05555, 17'h02AAA, 17'h05555},
  parameter logic [SET_LEN*DW-1:0] SET_DATAS = {8'hA0, 8'h55, 8'hAA},
  parameter logic [CLR_LEN*AW-1:0] CLR_ADDRS = {17'h05555, 17'h02AAA, 17'h05555,
                                                17'h05555, 17'h02AAA, 17'h05555},
  parameter logic [CLR_LEN*DW-1:0] CLR_DATAS = {8'h20, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          permit_o,
  output logic          prot_o,
  output logic          busy_o
);
  logic  step;
  logic  set_hit, set_done, clr_hit, clr_done;
  logic  win_active, win_permit, win_open;
  logic  tmr_start;
  flag_e tmr_target;

  assign step = wr_i && !busy_o && !win_active;

  wp_seq_match #(
    .AW(AW), .DW(DW), .LEN(SET_LEN), .ADDRS(SET_ADDRS), .DATAS(SET_DATAS)
  ) u_set_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step),
    .addr_i(addr_i), .data_i(data_i), .hit_o(set_hit), .done_o(set_done)
  );

  wp_seq_match #(
    .AW(AW), .DW(DW), .LEN(CLR_LEN), .ADDRS(CLR_ADDRS), .DATAS(CLR_DATAS)
  ) u_clr_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step),
    .addr_i(addr_i), .data_i(data_i), .hit_o(clr_hit), .done_o(clr_done)
  );

  // clear run wins if both ever complete together
  assign tmr_start  = clr_done || (set_done && !prot_o);
  assign tmr_target = clr_done ? FLAG_OFF : FLAG_ON;
  assign win_open   = set_done && !clr_done && prot_o;

  wp_flag_timer #(.TWC_CYCLES(TWC_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tmr_start), .target_i(tmr_target),
    .busy_o(busy_o), .prot_o(prot_o)
  );

  wp_page_window #(
    .AW(AW), .PAGE_BITS(PAGE_BITS), .LOAD_WIN_CYCLES(LOAD_WIN_CYCLES)
  ) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .open_i(win_open), .wr_i(wr_i),
    .addr_i(addr_i), .active_o(win_active), .permit_o(win_permit)
  );

  always_comb begin
    if (!wr_i || busy_o)  permit_o = 1'b0;
    else if (win_active)  permit_o = win_permit;
    else                  permit_o = !(set_hit || clr_hit) && !prot_o;
  end

  assert_busy_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !permit_o);

  assert_protected_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_o && !win_active) |-> !permit_o);

  assert_unlock_no_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_open |=> (win_active && !busy_o));

  assert_command_consumed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hit || clr_hit) |-> !permit_o);
endmodule

// File: tb/wp_cmd_detect_tb_top.sv
`timescale 1ns/1ps
module wp_cmd_detect_tb_top;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int PB = 8;
  localparam int TWC = 40;
  localparam int LW = 16;
  localparam int PAGE = 1 << PB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic permit, prot, busy;

  always #4 clk = ~clk;

  wp_cmd_detect #(
    .AW(AW), .DW(DW), .PAGE_BITS(PB), .TWC_CYCLES(TWC), .LOAD_WIN_CYCLES(LW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .permit_o(permit), .prot_o(prot), .busy_o(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  int cycles = 0;

  int set_a[3] = '{'h5555, 'h2AAA, 'h5555};
  int set_d[3] = '{'hAA, 'h55, 'hA0};
  int clr_a[6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
  int clr_d[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};

  // reference model state
  bit m_prot, m_busy, m_pend, m_win;
  int m_cnt, m_set, m_clr, m_bytes, m_page, m_idle;

  function automatic bit set_match();
    return wr && int'(addr) == set_a[m_set] && int'(data) == set_d[m_set];
  endfunction
  function automatic bit clr_match();
    return wr && int'(addr) == clr_a[m_clr] && int'(data) == clr_d[m_clr];
  endfunction
  function automatic bit exp_permit();
    if (!wr || m_busy) return 0;
    if (m_win) return (m_page < 0 || m_page == int'(addr >> PB));
    return !set_match() && !clr_match() && !m_prot;
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prot = 0; m_busy = 0; m_pend = 0; m_win = 0;
      m_cnt = 0; m_set = 0; m_clr = 0; m_bytes = 0; m_page = -1; m_idle = 0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin m_busy = 0; m_prot = m_pend; end
      else m_cnt--;
    end else if (m_win) begin
      if (wr) begin
        m_idle = 0;
        if (m_page < 0 || m_page == int'(addr >> PB)) begin
          m_page = int'(addr >> PB);
          m_bytes++;
          if (m_bytes == PAGE) m_win = 0;
        end else m_win = 0;
      end else begin
        m_idle++;
        if (m_idle == LW) m_win = 0;
      end
    end else if (wr) begin
      bit sh, ch, sd, cd;
      sh = set_match(); ch = clr_match();
      sd = sh && m_set == 2; cd = ch && m_clr == 5;
      m_set = (sh && !sd) ? m_set + 1 : 0;
      m_clr = (ch && !cd) ? m_clr + 1 : 0;
      if (cd) begin m_busy = 1; m_cnt = TWC - 1; m_pend = 0; end
      else if (sd) begin
        if (m_prot) begin m_win = 1; m_bytes = 0; m_page = -1; m_idle = 0; end
        else begin m_busy = 1; m_cnt = TWC - 1; m_pend = 1; end
      end
    end
  end

  // compare against the model every cycle, away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(cur_req, permit, exp_permit(), "permit_o");
      chk(cur_req, prot, m_prot, "prot_o");
      chk(cur_req, busy, m_busy, "busy_o");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr_cyc(int a, int d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(a); data = DW'(d);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr = 1'b0;
    end
  endtask
  task automatic wr_chk(string req, int a, int d, logic exp);
    wr_cyc(a, d);
    #1 chk(req, permit, exp, "permit_o on write");
  endtask
  task automatic set_run(string req);
    for (int i = 0; i < 3; i++) wr_chk(req, set_a[i], set_d[i], 1'b0);
  endtask
  task automatic clr_run(string req);
    for (int i = 0; i < 6; i++) wr_chk(req, clr_a[i], clr_d[i], 1'b0);
  endtask

  initial begin
    // R1 reset state
    #1 chk("R1", prot, 1'b0, "prot_o in reset");
    chk("R1", busy, 1'b0, "busy_o in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    wr_chk("R1", 'h0100, 'h11, 1'b1);
    idle(1);

    cur_req = "R2";
    wr_chk("R2", 'h1FFFF, 'h00, 1'b1);
    wr_chk("R2", 'h0000, 'hFF, 1'b1);
    wr_chk("R2", 'h5555, 'h55, 1'b1);
    wr_chk("R2", 'h2AAA, 'hAA, 1'b1);
    idle(2);

    cur_req = "R10";
    wr_chk("R10", 'h5555, 'hAA, 1'b0);
    wr_chk("R10", 'h2AAA, 'h55, 1'b0);
    wr_chk("R10", 'h0123, 'h12, 1'b1);
    wr_chk("R10", 'h5555, 'hA0, 1'b1);
    idle(2);
    chk("R10", busy, 1'b0, "busy_o after broken run");

    cur_req = "R3";
    set_run("R3");
    idle(1);
    #1 chk("R3", busy, 1'b1, "busy_o after set run");
    chk("R3", prot, 1'b0, "prot_o during delay");

    cur_req = "R4";
    wr_chk("R4", 'h0200, 'h33, 1'b0);
    wr_chk("R4", 'h5555, 'hAA, 1'b0);
    wr_chk("R4", 'h2AAA, 'h55, 1'b0);
    idle(TWC);
    #1 chk("R3", prot, 1'b1, "prot_o after delay");
    chk("R3", busy, 1'b0, "busy_o after delay");
    wr_chk("R4", 'h5555, 'hA0, 1'b0);
    wr_chk("R4", 'h1234, 'h5A, 1'b0);
    idle(2);

    cur_req = "R5";
    wr_chk("R5", 'h0000, 'h01, 1'b0);
    wr_chk("R5", 'h1FFFF, 'hFE, 1'b0);
    idle(2);

    cur_req = "R6";
    set_run("R6");
    #1 chk("R6", busy, 1'b0, "busy_o on unlock");
    for (int i = 0; i < PAGE; i++) wr_chk("R6", ('h12 << PB) | i, i, 1'b1);
    wr_chk("R6", ('h12 << PB) | 5, 'h77, 1'b0);
    idle(2);
    chk("R6", prot, 1'b1, "prot_o after page");

    cur_req = "R7";
    set_run("R7");
    wr_chk("R7", ('h03 << PB) | 1, 'h10, 1'b1);
    wr_chk("R7", ('h03 << PB) | 2, 'h11, 1'b1);
    wr_chk("R7", ('h04 << PB) | 2, 'h12, 1'b0);
    wr_chk("R7", ('h03 << PB) | 3, 'h13, 1'b0);
    idle(2);

    cur_req = "R8";
    set_run("R8");
    wr_chk("R8", ('h07 << PB) | 0, 'h21, 1'b1);
    idle(LW - 1);
    wr_chk("R8", ('h07 << PB) | 1, 'h22, 1'b1);
    idle(LW);
    wr_chk("R8", ('h07 << PB) | 2, 'h23, 1'b0);
    idle(1);
    #1 chk("R8", busy, 1'b0, "busy_o after window close");
    chk("R8", prot, 1'b1, "prot_o after window close");
    set_run("R8");
    idle(LW);
    wr_chk("R8", 'h0040, 'h24, 1'b0);
    idle(2);

    cur_req = "R9";
    clr_run("R9");
    idle(1);
    #1 chk("R9", busy, 1'b1, "busy_o after clear run");
    chk("R9", prot, 1'b1, "prot_o during clear delay");
    idle(TWC);
    #1 chk("R9", prot, 1'b0, "prot_o after clear delay");
    wr_chk("R9", 'h0300, 'h44, 1'b1);
    idle(2);

    cur_req = "R11";
    wr_chk("R11", 'h5555, 'hAA, 1'b0);
    wr_chk("R11", 'h2AAA, 'h55, 1'b0);
    wr_chk("R11", 'h5555, 'h80, 1'b0);
    wr_chk("R11", 'h5555, 'hAA, 1'b0);
    wr_chk("R11", 'h2AAA, 'h55, 1'b0);
    wr_chk("R11", 'h5555, 'hA0, 1'b0);
    idle(TWC + 2);
    #1 chk("R11", prot, 1'b1, "prot_o after shared prefix");
    clr_run("R11");
    idle(TWC + 2);
    #1 chk("R11", prot, 1'b0, "prot_o after final clear");

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule